// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block carries 36-bit words from one clock domain to another. A producer writes on `wr_clk` and a consumer reads on `rd_clk`. Each side accepts an access only when all four of its qualifiers agree: the enable, the request, the direction line and the resource select. The FIFO holds 256 words. The read side always shows the oldest stored word on `rd_data`, which behaves like a show-ahead output gated by an output enable. Each read retires that word.

Four status outputs are provided. Full and almost-full belong to the write domain. Empty and almost-empty belong to the read domain. The two almost-flag thresholds sit in offset registers that the write port loads through its resource select. A low level on the asynchronous `rst_n` clears both pointers, forces the empty condition and reloads both offsets with eight.

Pointers cross between the domains in Gray code through two-flop synchronisers. As a result, a flag that depends on the other domain is pessimistic. Full and almost-full release late. Empty and almost-empty release late.

Each domain has a status state machine:
- Write side states: `W_ROOM`, `W_NEAR` and `W_FULL`.
- Read side states: `R_EMPTY`, `R_LOW` and `R_AVAIL`.

Every clock, each side computes the next fill level from its own next pointer and the synchronised opposite pointer, then moves to the state that level selects. Any state can move to any other:
- `W_ROOM`→`W_NEAR` when the free space falls to the almost-full offset or below.
- `W_NEAR`→`W_FULL` at 256 words.
- `W_FULL`→`W_NEAR`/`W_ROOM` once reads are seen.
- `R_EMPTY`→`R_LOW` when the first word is seen.
- `R_LOW`→`R_AVAIL` when the level exceeds the almost-empty offset.
- The reverse read-side moves happen as reads drain the FIFO.

Top module: `pfifo_dc`

## Requirements
- R1: While `rst_n` is low and after its release, `empty` and `almost_empty` are 1 and `full` and `almost_full` are 0. Both offsets return to 8 on any reset, including one in mid-operation.
- R2: A word is stored on a rising `wr_clk` only when `wr_en`=1, `wr_req`=1, `wr_rnw`=0 and `wr_sel`=3'b000. Any other combination stores nothing.
- R3: A word is retired on a rising `rd_clk` only when `rd_en`=1, `rd_req`=1, `rd_rnw`=1 and `rd_sel`=0. Any other combination leaves the head word in place.
- R4: Words leave in the order written. `rd_data` shows the head word when `rd_oe`=1 and is all zeros when `rd_oe`=0.
- R5: While `full`=1, write attempts are ignored. The 256 stored words are not disturbed and the write pointer does not move.
- R6: A read while `empty`=1 is ignored. The first read from a full FIFO makes `full` return to 0.
- R7: `almost_empty`=1 whenever the fill level is less than or equal to the almost-empty offset. `empty` implies `almost_empty`.
- R8: `almost_full`=1 whenever 256 minus the fill level is less than or equal to the almost-full offset. `full` implies `almost_full`.
- R9: A qualified write-port access with `wr_sel`=3'b100 loads the almost-empty offset from `wr_data[7:0]`. With `wr_sel`=3'b101 it loads the almost-full offset. A value of 0 is stored as 1, and such an access stores no FIFO word.
- R10: Each stored pointer changes by at most one bit per clock of its own domain, as Gray code requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write-port enable |
| wr_req | input | 1 | Write-port request |
| wr_rnw | input | 1 | Write-port direction, 0 = write |
| wr_sel | input | 3 | Write-port resource select (000 FIFO, 100 AE offset, 101 AF offset) |
| wr_data | input | 36 | Word to store, low 8 bits also carry offsets |
| rd_en | input | 1 | Read-port enable |
| rd_req | input | 1 | Read-port request |
| rd_rnw | input | 1 | Read-port direction, 1 = read |
| rd_sel | input | 1 | Read-port resource select (0 FIFO) |
| rd_oe | input | 1 | Output enable for `rd_data` |
| rd_data | output | 36 | Head word, zero when disabled |
| empty | output | 1 | No words visible to the read side |
| almost_empty | output | 1 | Fill level at or below AE offset |
| full | output | 1 | 256 words as seen by the write side |
| almost_full | output | 1 | Free space at or below AF offset |

## Verification
The hardest situation to reach is the boundary of a full FIFO. The bench has to fill all 256 locations, offer a stray write while `full` is high, then retire exactly one word and watch `full` drop after the synchroniser delay. Directed bursts reach it by writing 247 words, checking that `almost_full` is still clear, adding one word to cross the threshold, and then topping up to 256. Draining everything afterwards proves the stray word never entered, and also exercises pointer wrap. The same pattern, run with reprogrammed offsets, moves both thresholds.

// File: rtl/pfifo_pkg.sv
`timescale 1ns/1ps
package pfifo_pkg;

    typedef enum logic [1:0] {
        W_ROOM = 2'd0,
        W_NEAR = 2'd1,
        W_FULL = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_EMPTY = 2'd0,
        R_LOW   = 2'd1,
        R_AVAIL = 2'd2
    } rd_state_e;

    localparam logic [2:0] SEL_FIFO   = 3'b000;
    localparam logic [2:0] SEL_MBOX   = 3'b001;
    localparam logic [2:0] SEL_AE_OFF = 3'b100;
    localparam logic [2:0] SEL_AF_OFF = 3'b101;

endpackage

// File: rtl/pfifo_sync.sv
`timescale 1ns/1ps
module pfifo_sync #(
    parameter int            W       = 9,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pfifo_mem.sv
`timescale 1ns/1ps
module pfifo_mem #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] ram [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];
endmodule

// File: rtl/pfifo_wr_ctl.sv
`timescale 1ns/1ps
module pfifo_wr_ctl
    import pfifo_pkg::*;
#(
    parameter int AW      = 8,
    parameter int OFF_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          req,
    input  logic          rnw,
    input  logic [2:0]    sel,
    input  logic [AW-1:0] off_data,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [AW-1:0] ae_off,
    output logic          full,
    output logic          almost_full
);
    localparam int            PW    = AW + 1;
    localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
    localparam logic [AW-1:0] ORST  = AW'(OFF_RST);

    wr_state_e     st, st_n;
    logic          access;
    logic [PW-1:0] wbin, wbin_n, rbin_s, count_n, free_n;
    logic [AW-1:0] af_off, off_clip;

    assign access   = en && req && !rnw;
    assign we       = access && (sel == SEL_FIFO) && (st != W_FULL);
    assign wbin_n   = wbin + PW'(we);
    assign waddr    = wbin[AW-1:0];
    assign off_clip = (off_data == '0) ? AW'(1) : off_data;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    end

    assign count_n = wbin_n - rbin_s;
    assign free_n  = DEPTH - count_n;

    // next-state selection
    always_comb begin
        if (count_n == DEPTH)                 st_n = W_FULL;
        else if (free_n <= {1'b0, af_off})    st_n = W_NEAR;
        else                                  st_n = W_ROOM;
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= W_ROOM;
            wbin  <= '0;
            wgray <= '0;
        end else begin
            st    <= st_n;
            wbin  <= wbin_n;
            wgray <= wbin_n ^ (wbin_n >> 1);
        end
    end

    // offset registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_off <= ORST;
            af_off <= ORST;
        end else if (access) begin
            if (sel == SEL_AE_OFF) ae_off <= off_clip;
            if (sel == SEL_AF_OFF) af_off <= off_clip;
        end
    end

    // outputs from state
    always_comb begin
        full        = 1'b0;
        almost_full = 1'b0;
        unique case (st)
            W_ROOM: begin full = 1'b0; almost_full = 1'b0; end
            W_NEAR: begin full = 1'b0; almost_full = 1'b1; end
            W_FULL: begin full = 1'b1; almost_full = 1'b1; end
            default: begin full = 1'b0; almost_full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pfifo_rd_ctl.sv
`timescale 1ns/1ps
module pfifo_rd_ctl
    import pfifo_pkg::*;
#(
    parameter int AW      = 8,
    parameter int OFF_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          req,
    input  logic          rnw,
    input  logic          sel,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_off_w,
    output logic [AW:0]   rgray,
    output logic [AW-1:0] raddr,
    output logic          empty,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    rd_state_e     st, st_n;
    logic          access, re;
    logic [PW-1:0] rbin, rbin_n, wbin_s, count_n;
    logic [AW-1:0] ae_off;

    pfifo_sync #(.W(AW), .RST_VAL(AW'(OFF_RST))) u_off_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ae_off_w),
        .q     (ae_off)
    );

    assign access = en && req && rnw && !sel;
    assign re     = access && (st != R_EMPTY);
    assign rbin_n = rbin + PW'(re);
    assign raddr  = rbin[AW-1:0];

    always_comb begin
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
    end

    assign count_n = wbin_s - rbin_n;

    always_comb begin
        if (count_n == '0)                    st_n = R_EMPTY;
        else if (count_n <= {1'b0, ae_off})   st_n = R_LOW;
        else                                  st_n = R_AVAIL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= R_EMPTY;
            rbin  <= '0;
            rgray <= '0;
        end else begin
            st    <= st_n;
            rbin  <= rbin_n;
            rgray <= rbin_n ^ (rbin_n >> 1);
        end
    end

    always_comb begin
        empty        = 1'b1;
        almost_empty = 1'b1;
        unique case (st)
            R_EMPTY: begin empty = 1'b1; almost_empty = 1'b1; end
            R_LOW:   begin empty = 1'b0; almost_empty = 1'b1; end
            R_AVAIL: begin empty = 1'b0; almost_empty = 1'b0; end
            default: begin empty = 1'b1; almost_empty = 1'b1; end
        endcase
    end
endmodule

// File: rtl/pfifo_dc.sv
`timescale 1ns/1ps
module pfifo_dc #(
    parameter int DW      = 36,
    parameter int AW      = 8,
    parameter int OFF_RST = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_req,
    input  logic          wr_rnw,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          rd_req,
    input  logic          rd_rnw,
    input  logic          rd_sel,
    input  logic          rd_oe,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          almost_full
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr, ae_off;
    logic          we;
    logic [DW-1:0] head;

    pfifo_wr_ctl #(.AW(AW), .OFF_RST(OFF_RST)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .en          (wr_en),
        .req         (wr_req),
        .rnw         (wr_rnw),
        .sel         (wr_sel),
        .off_data    (wr_data[AW-1:0]),
        .rgray_s     (rgray_s),
        .wgray       (wgray),
        .waddr       (waddr),
        .we          (we),
        .ae_off      (ae_off),
        .full        (full),
        .almost_full (almost_full)
    );

    pfifo_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    pfifo_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    pfifo_rd_ctl #(.AW(AW), .OFF_RST(OFF_RST)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .en           (rd_en),
        .req          (rd_req),
        .rnw          (rd_rnw),
        .sel          (rd_sel),
        .wgray_s      (wgray_s),
        .ae_off_w     (ae_off),
        .rgray        (rgray),
        .raddr        (raddr),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    pfifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wr_clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (head)
    );

    assign rd_data = rd_oe ? head : '0;
endmodule

// File: rtl/pfifo_dc_chk.sv
`timescale 1ns/1ps
module pfifo_dc_chk #(
    parameter int AW = 8
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_req,
    input logic        wr_rnw,
    input logic [2:0]  wr_sel,
    input logic        rd_en,
    input logic        rd_req,
    input logic        rd_rnw,
    input logic        rd_sel,
    input logic        empty,
    input logic        almost_empty,
    input logic        full,
    input logic        almost_full,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray
);
    logic wr_q, rd_q;
    assign wr_q = wr_en && wr_req && !wr_rnw && (wr_sel == 3'b000);
    assign rd_q = rd_en && rd_req && rd_rnw && !rd_sel;

    a_r2_write_advances: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_q && !full) |=> (wgray != $past(wgray)));
    a_r2_unqualified_holds: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_q |=> $stable(wgray));
    a_r3_unqualified_holds: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_q |=> $stable(rgray));
    a_r5_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |=> $stable(wgray));
    a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |=> $stable(rgray));
    a_r7_empty_is_low: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> almost_empty);
    a_r8_full_is_high: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> almost_full);
    a_r10_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    a_r10_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind pfifo_dc pfifo_dc_chk #(.AW(AW)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_req       (wr_req),
    .wr_rnw       (wr_rnw),
    .wr_sel       (wr_sel),
    .rd_en        (rd_en),
    .rd_req       (rd_req),
    .rd_rnw       (rd_rnw),
    .rd_sel       (rd_sel),
    .empty        (empty),
    .almost_empty (almost_empty),
    .full         (full),
    .almost_full  (almost_full),
    .wgray        (wgray),
    .rgray        (rgray)
);

// File: tb/pfifo_dc_bench.sv
`timescale 1ns/1ps
module pfifo_dc_bench;
    logic        wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 0, wr_req = 0, wr_rnw = 0;
    logic [2:0]  wr_sel = 3'b000;
    logic [35:0] wr_data = '0;
    logic        rd_en = 0, rd_req = 0, rd_rnw = 0, rd_sel = 0, rd_oe = 1;
    logic [35:0] rd_data;
    logic        empty, almost_empty, full, almost_full;
    int          n_tests = 0, n_fail = 0;
    bit          done = 0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    pfifo_dc u_pfifo_dc (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_req(wr_req), .wr_rnw(wr_rnw), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_req(rd_req), .rd_rnw(rd_rnw), .rd_sel(rd_sel), .rd_oe(rd_oe),
        .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty),
        .full(full), .almost_full(almost_full)
    );

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge rd_clk);
        repeat (3) @(posedge wr_clk);
        #1 rst_n = 1'b1;
        settle();
    endtask

    task automatic wr_burst(input logic [35:0] base, input int n);
        @(posedge wr_clk); #1;
        wr_en = 1; wr_req = 1; wr_rnw = 0; wr_sel = 3'b000;
        for (int i = 0; i < n; i++) begin
            wr_data = base + 36'(i);
            @(posedge wr_clk); #1;
        end
        wr_en = 0; wr_req = 0;
    endtask

    task automatic wr_try(input logic e, input logic q, input logic rw,
                          input logic [2:0] s, input logic [35:0] d);
        @(posedge wr_clk); #1;
        wr_en = e; wr_req = q; wr_rnw = rw; wr_sel = s; wr_data = d;
        @(posedge wr_clk); #1;
        wr_en = 0; wr_req = 0; wr_rnw = 0; wr_sel = 3'b000;
    endtask

    task automatic rd_burst(input logic [35:0] base, input int n, input string tag);
        @(posedge rd_clk); #1;
        rd_en = 1; rd_req = 1; rd_rnw = 1; rd_sel = 0;
        for (int i = 0; i < n; i++) begin
            check(tag, rd_data, base + 36'(i));
            @(posedge rd_clk); #1;
        end
        rd_en = 0; rd_req = 0; rd_rnw = 0;
    endtask

    task automatic rd_try(input logic e, input logic q, input logic rw, input logic s);
        @(posedge rd_clk); #1;
        rd_en = e; rd_req = q; rd_rnw = rw; rd_sel = s;
        @(posedge rd_clk); #1;
        rd_en = 0; rd_req = 0; rd_rnw = 0; rd_sel = 0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 empty", 36'(empty), 36'd1);
        check("R1 almost_empty", 36'(almost_empty), 36'd1);
        check("R1 full", 36'(full), 36'd0);
        check("R1 almost_full", 36'(almost_full), 36'd0);
    endtask

    task automatic t_order_oe();
        wr_burst(36'h5A0, 3);
        settle();
        check("R4 not empty", 36'(empty), 36'd0);
        rd_oe = 0; #1;
        check("R4 oe low zero", rd_data, 36'd0);
        rd_oe = 1; #1;
        rd_burst(36'h5A0, 3, "R4 order");
        settle();
        check("R4 drained", 36'(empty), 36'd1);
    endtask

    task automatic t_write_qual();
        wr_try(0, 1, 0, 3'b000, 36'h11);
        wr_try(1, 0, 0, 3'b000, 36'h12);
        wr_try(1, 1, 1, 3'b000, 36'h13);
        wr_try(1, 1, 0, 3'b001, 36'h14);
        wr_try(1, 1, 0, 3'b010, 36'h15);
        settle();
        check("R2 bad qualifiers store nothing", 36'(empty), 36'd1);
        wr_try(1, 1, 0, 3'b000, 36'h77);
        settle();
        check("R2 good write visible", 36'(empty), 36'd0);
        check("R2 good write data", rd_data, 36'h77);
    endtask

    task automatic t_read_qual();
        rd_try(0, 1, 1, 0);
        rd_try(1, 0, 1, 0);
        rd_try(1, 1, 0, 0);
        rd_try(1, 1, 1, 1);
        settle();
        check("R3 head kept", rd_data, 36'h77);
        check("R3 still not empty", 36'(empty), 36'd0);
        rd_try(1, 1, 1, 0);
        settle();
        check("R3 good read retires", 36'(empty), 36'd1);
    endtask

    task automatic t_empty_read();
        rd_try(1, 1, 1, 0);
        rd_try(1, 1, 1, 0);
        wr_burst(36'h9C1, 1);
        settle();
        check("R6 read on empty ignored", rd_data, 36'h9C1);
        rd_burst(36'h9C1, 1, "R6 single");
        settle();
    endtask

    task automatic t_ae_default();
        wr_burst(36'h300, 8);
        settle();
        check("R7 ae at 8", 36'(almost_empty), 36'd1);
        wr_burst(36'h308, 1);
        settle();
        check("R7 ae clear at 9", 36'(almost_empty), 36'd0);
        rd_burst(36'h300, 9, "R7 drain");
        settle();
    endtask

    task automatic t_full();
        wr_burst(36'h100, 247);
        settle();
        check("R8 af clear at free 9", 36'(almost_full), 36'd0);
        wr_burst(36'h100 + 36'd247, 1);
        settle();
        check("R8 af set at free 8", 36'(almost_full), 36'd1);
        check("R8 not full at 248", 36'(full), 36'd0);
        wr_burst(36'h100 + 36'd248, 8);
        settle();
        check("R5 full at 256", 36'(full), 36'd1);
        wr_burst(36'hDEAD, 2);
        settle();
        check("R5 still full", 36'(full), 36'd1);
        rd_burst(36'h100, 1, "R5 first word");
        settle();
        check("R6 full released", 36'(full), 36'd0);
        rd_burst(36'h101, 255, "R5 contents");
        settle();
        check("R5 stray word absent", 36'(empty), 36'd1);
    endtask

    task automatic t_program();
        wr_try(1, 1, 0, 3'b100, 36'd3);
        wr_try(1, 1, 0, 3'b101, 36'd20);
        settle();
        check("R9 offset write stores no word", 36'(empty), 36'd1);
        wr_burst(36'h700, 3);
        settle();
        check("R9 ae at 3", 36'(almost_empty), 36'd1);
        wr_burst(36'h703, 1);
        settle();
        check("R9 ae clear at 4", 36'(almost_empty), 36'd0);
        wr_burst(36'h704, 231);
        settle();
        check("R9 af clear at 235", 36'(almost_full), 36'd0);
        wr_burst(36'h704 + 36'd231, 1);
        settle();
        check("R9 af set at 236", 36'(almost_full), 36'd1);
        do_reset();
        check("R1 mid reset empty", 36'(empty), 36'd1);
        check("R1 mid reset af", 36'(almost_full), 36'd0);
        wr_burst(36'h800, 8);
        settle();
        check("R1 ae offset back to 8", 36'(almost_empty), 36'd1);
        wr_burst(36'h808, 1);
        settle();
        check("R1 ae clear at 9", 36'(almost_empty), 36'd0);
        rd_burst(36'h800, 9, "R1 drain");
        settle();
        wr_try(1, 1, 0, 3'b100, 36'd0);
        wr_burst(36'h900, 1);
        settle();
        check("R9 zero offset acts as 1", 36'(almost_empty), 36'd1);
        wr_burst(36'h901, 1);
        settle();
        check("R9 ae clear at 2", 36'(almost_empty), 36'd0);
    endtask

    initial begin
        t_reset();
        t_order_oe();
        t_write_qual();
        t_read_qual();
        t_empty_read();
        t_ae_default();
        t_full();
        t_program();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1-R10 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule